// File: doc/BRIEF.md
# Planar Display Memory Access Path

This block sits between a byte-wide host port and a display memory organised as four byte planes side by side in one 32-bit word. Each host write or read is turned into a single word access with per-plane byte enables. The address mapping is chosen by two configuration flags. In chained mode the low address bits pick the plane. In paired mode an odd or even address picks one plane of a pair. With both flags clear the block uses latched planar mode, where one host byte addresses a whole word that spans all four planes.

In latched planar mode a read loads a 32-bit latch from the addressed word. The host then sees either one plane of the latch or a colour-compare result. A write builds a new word from the host byte, the latch and the configuration inputs, using one of four write modes, a 3-bit rotation, per-plane set/reset, a two-bit logic function and a bit mask, and stores it under a per-plane enable. All configuration arrives as plain input ports. The memory is expected to return read data one clock after its read strobe.

Top module: `vgapl_plane_access`

## Requirements
- R1: After reset `host_rvalid` is 0 and the latch holds zero, so a latched-mode copy write (write mode 1) stores 0 to every enabled plane.
- R2: With `cfg_chain4`=1 the word address is the host address shifted right by two and the plane is address bits 1:0. A write drives the host byte on every lane and sets the enable of that plane only when its bit in `cfg_plane_en` is 1. A read returns that plane's byte of the word and leaves the latch unchanged. Chained mode takes priority over paired mode.
- R3: With `cfg_chain4`=0 and `cfg_oddeven`=1 the plane is {`cfg_read_plane`[1], address bit 0} and the word address is the host address shifted right by one. Writes are gated by that plane's bit in `cfg_plane_en`, and reads return that plane's byte.
- R4: In latched mode every read loads the latch with the addressed word. With `cfg_read_mode`=0 the read returns the byte of plane `cfg_read_plane` (plane p occupies bits 8p+7:8p).
- R5: With `cfg_read_mode`=1 result bit i is 1 exactly when, for every plane p with `cfg_cmp_care`[p]=1, bit i of plane p of the loaded word equals `cfg_cmp_color`[p].
- R6: Write mode 0 (`cfg_write_mode`=0) rotates the host byte right by `cfg_rotate` and sends it to each plane. A plane whose `cfg_sr_enable` bit is 1 receives instead all-ones or all-zeros, as given by its `cfg_sr_value` bit.
- R7: Write mode 1 stores the latch unchanged. The logic function and the bit mask are skipped.
- R8: Write mode 2 gives plane p all-ones if host data bit p is 1, otherwise all-zeros.
- R9: Write mode 3 gives every plane its `cfg_sr_value` bit expanded to all-ones or all-zeros, and uses (rotated host byte AND `cfg_bit_mask`) as the bit mask.
- R10: In write modes 0, 2 and 3 `cfg_alu_op` combines the data with the latch plane: 0 passes the data, 1 ANDs it with the latch, 2 ORs it and 3 XORs it.
- R11: After the logic function, bit i of every plane comes from the function result where the bit mask is 1 and from the latch where it is 0.
- R12: A latched-mode write drives `mem_we` in the same cycle as `host_wr`, with `mem_be` equal to `cfg_plane_en` and the word address equal to the host address.
- R13: A read strobe gives `host_rvalid` and `host_rdata` in the following cycle. When `host_rd` and `host_wr` are both high in the same cycle, the write is performed and the read is dropped: there is no `mem_re` and no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | LANE_W | Host write byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | LANE_W | Read result, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid |
| cfg_chain4 | input | 1 | Chained addressing |
| cfg_oddeven | input | 1 | Paired odd/even addressing |
| cfg_read_mode | input | 1 | 0 plane select, 1 colour compare |
| cfg_read_plane | input | LANE_IW | Plane for read mode 0; bit 1 picks the pair in paired mode |
| cfg_write_mode | input | 2 | Latched write mode 0..3 |
| cfg_rotate | input | ROT_W | Right-rotate count |
| cfg_alu_op | input | 2 | Logic function |
| cfg_sr_value | input | PLANES | Set/reset value per plane |
| cfg_sr_enable | input | PLANES | Set/reset enable per plane |
| cfg_bit_mask | input | LANE_W | Bit mask |
| cfg_plane_en | input | PLANES | Plane write enables |
| cfg_cmp_color | input | PLANES | Compare colour |
| cfg_cmp_care | input | PLANES | Compare plane enables |
| mem_addr | output | HOST_AW | Memory word address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | PLANES | Byte (plane) enables |
| mem_wdata | output | WORD_W | Memory write word |
| mem_rdata | input | WORD_W | Memory read word, one cycle after mem_re |

## Verification
The assertions check the cycle-level contract on every clock. They cover the one-cycle read response and the dropped read under a simultaneous write, byte enables that never exceed the plane enables, a single enabled lane in chained mode, and the shifted word addresses of the chained and paired mappings. The data arithmetic is shown only by the bench's sweeps: every write mode is tried against every logic function with varied rotations, set/reset values and masks, and all 256 compare-colour/care combinations are read back. The bench scenarios also show that a chained read leaves the latch alone, and that the latch is forwarded to a write issued in the cycle its read data returns.

// File: rtl/vgapl_pkg.sv
package vgapl_pkg;
   typedef enum logic [1:0] {
      AM_LATCHED = 2'd0,
      AM_ODDEVEN = 2'd1,
      AM_CHAIN   = 2'd2
   } amode_t;

   typedef enum logic [1:0] {
      WM_ROTSR  = 2'd0,
      WM_COPY   = 2'd1,
      WM_EXPAND = 2'd2,
      WM_MASKED = 2'd3
   } wmode_t;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_AND  = 2'd1,
      ALU_OR   = 2'd2,
      ALU_XOR  = 2'd3
   } aluop_t;
endpackage

// File: rtl/vgapl_addr_map.sv
module vgapl_addr_map
   import vgapl_pkg::*;
#(
   parameter int HOST_AW = 16,
   parameter int LANE_IW = 2
) (
   input  logic [HOST_AW-1:0] addr,
   input  logic               chain4,
   input  logic               oddeven,
   input  logic [LANE_IW-1:1] pair_sel,
   output amode_t             amode,
   output logic [HOST_AW-1:0] word_addr,
   output logic [LANE_IW-1:0] lane
);
   always_comb begin
      if (chain4) begin
         amode     = AM_CHAIN;
         word_addr = addr >> LANE_IW;
         lane      = addr[LANE_IW-1:0];
      end else if (oddeven) begin
         amode     = AM_ODDEVEN;
         word_addr = addr >> 1;
         lane      = {pair_sel, addr[0]};
      end else begin
         amode     = AM_LATCHED;
         word_addr = addr;
         lane      = '0;
      end
   end
endmodule

// File: rtl/vgapl_write_path.sv
module vgapl_write_path
   import vgapl_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int PLANES = 4,
   parameter int ROT_W  = $clog2(LANE_W),
   parameter int WORD_W = PLANES * LANE_W
) (
   input  logic [LANE_W-1:0] din,
   input  logic [WORD_W-1:0] latch,
   input  wmode_t            wmode,
   input  logic [ROT_W-1:0]  rot,
   input  aluop_t            alu,
   input  logic [PLANES-1:0] sr_val,
   input  logic [PLANES-1:0] sr_en,
   input  logic [LANE_W-1:0] bit_mask,
   output logic [WORD_W-1:0] word_out
);
   logic [2*LANE_W-1:0] doubled;
   logic [LANE_W-1:0]   rotated;
   logic [LANE_W-1:0]   eff_mask;

   assign doubled  = {din, din} >> rot;
   assign rotated  = doubled[LANE_W-1:0];
   assign eff_mask = (wmode == WM_MASKED) ? (bit_mask & rotated) : bit_mask;

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      logic [LANE_W-1:0] lat_p, src_p, alu_p, merged_p;
      assign lat_p = latch[p*LANE_W +: LANE_W];

      always_comb begin
         unique case (wmode)
            WM_ROTSR:  src_p = sr_en[p] ? {LANE_W{sr_val[p]}} : rotated;
            WM_EXPAND: src_p = {LANE_W{din[p]}};
            WM_MASKED: src_p = {LANE_W{sr_val[p]}};
            default:   src_p = lat_p;
         endcase
         unique case (alu)
            ALU_PASS: alu_p = src_p;
            ALU_AND:  alu_p = src_p & lat_p;
            ALU_OR:   alu_p = src_p | lat_p;
            default:  alu_p = src_p ^ lat_p;
         endcase
         merged_p = (alu_p & eff_mask) | (lat_p & ~eff_mask);
      end

      assign word_out[p*LANE_W +: LANE_W] = (wmode == WM_COPY) ? lat_p : merged_p;
   end
endmodule

// File: rtl/vgapl_read_path.sv
module vgapl_read_path
   import vgapl_pkg::*;
#(
   parameter int LANE_W  = 8,
   parameter int PLANES  = 4,
   parameter int LANE_IW = $clog2(PLANES),
   parameter int WORD_W  = PLANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue,
   input  amode_t             amode,
   input  logic [LANE_IW-1:0] lane,
   input  logic               read_mode,
   input  logic [LANE_IW-1:0] read_plane,
   input  logic [PLANES-1:0]  cmp_color,
   input  logic [PLANES-1:0]  cmp_care,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic [LANE_W-1:0]  rdata,
   output logic               rvalid,
   output logic [WORD_W-1:0]  latch_eff
);
   logic               pend_q;
   amode_t             kind_q;
   logic [LANE_IW-1:0] lane_q;
   logic               mode_q;
   logic [PLANES-1:0]  color_q, care_q;
   logic [WORD_W-1:0]  latch_q;
   logic               load_now;
   logic [LANE_W-1:0]  cmp_res;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         kind_q  <= AM_LATCHED;
         lane_q  <= '0;
         mode_q  <= 1'b0;
         color_q <= '0;
         care_q  <= '0;
         latch_q <= '0;
      end else begin
         pend_q <= issue;
         if (issue) begin
            kind_q  <= amode;
            lane_q  <= (amode == AM_LATCHED) ? read_plane : lane;
            mode_q  <= read_mode;
            color_q <= cmp_color;
            care_q  <= cmp_care;
         end
         if (load_now) latch_q <= mem_rdata;
      end
   end

   assign load_now  = pend_q && (kind_q == AM_LATCHED);
   assign latch_eff = load_now ? mem_rdata : latch_q;
   assign rvalid    = pend_q;

   always_comb begin
      for (int i = 0; i < LANE_W; i++) begin
         logic miss;
         miss = 1'b0;
         for (int p = 0; p < PLANES; p++)
            miss = miss | (care_q[p] & (mem_rdata[p*LANE_W + i] ^ color_q[p]));
         cmp_res[i] = ~miss;
      end
   end

   assign rdata = (kind_q == AM_LATCHED && mode_q) ? cmp_res
                                                   : mem_rdata[lane_q*LANE_W +: LANE_W];
endmodule

// File: rtl/vgapl_plane_access.sv
module vgapl_plane_access
   import vgapl_pkg::*;
#(
   parameter int HOST_AW = 16,
   parameter int LANE_W  = 8,
   parameter int PLANES  = 4,
   parameter int ROT_W   = $clog2(LANE_W),
   parameter int LANE_IW = $clog2(PLANES),
   parameter int WORD_W  = PLANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [LANE_W-1:0]  host_wdata,
   input  logic               host_wr,
   input  logic               host_rd,
   output logic [LANE_W-1:0]  host_rdata,
   output logic               host_rvalid,
   input  logic               cfg_chain4,
   input  logic               cfg_oddeven,
   input  logic               cfg_read_mode,
   input  logic [LANE_IW-1:0] cfg_read_plane,
   input  logic [1:0]         cfg_write_mode,
   input  logic [ROT_W-1:0]   cfg_rotate,
   input  logic [1:0]         cfg_alu_op,
   input  logic [PLANES-1:0]  cfg_sr_value,
   input  logic [PLANES-1:0]  cfg_sr_enable,
   input  logic [LANE_W-1:0]  cfg_bit_mask,
   input  logic [PLANES-1:0]  cfg_plane_en,
   input  logic [PLANES-1:0]  cfg_cmp_color,
   input  logic [PLANES-1:0]  cfg_cmp_care,
   output logic [HOST_AW-1:0] mem_addr,
   output logic               mem_we,
   output logic               mem_re,
   output logic [PLANES-1:0]  mem_be,
   output logic [WORD_W-1:0]  mem_wdata,
   input  logic [WORD_W-1:0]  mem_rdata
);
   if (PLANES < 4 || (1 << LANE_IW) != PLANES) begin : g_bad_planes
      $error("PLANES must be a power of two of at least 4");
   end
   if (PLANES > LANE_W) begin : g_bad_lane
      $error("write mode 2 needs one host bit per plane");
   end
   if (HOST_AW <= LANE_IW) begin : g_bad_aw
      $error("HOST_AW too small for the plane index");
   end

   amode_t             amode;
   logic [HOST_AW-1:0] word_addr;
   logic [LANE_IW-1:0] lane;
   logic [WORD_W-1:0]  latch_eff;
   logic [WORD_W-1:0]  planar_word;
   logic [PLANES-1:0]  lane_oh;
   logic               rd_issue;

   vgapl_addr_map #(.HOST_AW(HOST_AW), .LANE_IW(LANE_IW)) u_map (
      .addr      (host_addr),
      .chain4    (cfg_chain4),
      .oddeven   (cfg_oddeven),
      .pair_sel  (cfg_read_plane[LANE_IW-1:1]),
      .amode     (amode),
      .word_addr (word_addr),
      .lane      (lane)
   );

   vgapl_write_path #(.LANE_W(LANE_W), .PLANES(PLANES)) u_wr (
      .din      (host_wdata),
      .latch    (latch_eff),
      .wmode    (wmode_t'(cfg_write_mode)),
      .rot      (cfg_rotate),
      .alu      (aluop_t'(cfg_alu_op)),
      .sr_val   (cfg_sr_value),
      .sr_en    (cfg_sr_enable),
      .bit_mask (cfg_bit_mask),
      .word_out (planar_word)
   );

   assign rd_issue = host_rd && !host_wr;

   vgapl_read_path #(.LANE_W(LANE_W), .PLANES(PLANES)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (rd_issue),
      .amode      (amode),
      .lane       (lane),
      .read_mode  (cfg_read_mode),
      .read_plane (cfg_read_plane),
      .cmp_color  (cfg_cmp_color),
      .cmp_care   (cfg_cmp_care),
      .mem_rdata  (mem_rdata),
      .rdata      (host_rdata),
      .rvalid     (host_rvalid),
      .latch_eff  (latch_eff)
   );

   assign lane_oh  = PLANES'(1) << lane;
   assign mem_addr = word_addr;
   assign mem_we   = host_wr;
   assign mem_re   = rd_issue;

   always_comb begin
      if (!host_wr)
         mem_be = '0;
      else if (amode == AM_LATCHED)
         mem_be = cfg_plane_en;
      else
         mem_be = cfg_plane_en & lane_oh;
   end

   assign mem_wdata = (amode == AM_LATCHED) ? planar_word : {PLANES{host_wdata}};
endmodule

// File: rtl/vgapl_checker.sv
module vgapl_checker #(
   parameter int HOST_AW = 16,
   parameter int PLANES  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [HOST_AW-1:0] host_addr,
   input logic               host_wr,
   input logic               host_rd,
   input logic               host_rvalid,
   input logic               cfg_chain4,
   input logic               cfg_oddeven,
   input logic [PLANES-1:0]  cfg_plane_en,
   input logic [HOST_AW-1:0] mem_addr,
   input logic               mem_re,
   input logic [PLANES-1:0]  mem_be
);
   localparam int LIW = $clog2(PLANES);

   assert_rvalid_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> host_rvalid);
   assert_no_stray_rvalid_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && !host_wr) |=> !host_rvalid);
   assert_read_dropped_R13: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |-> !mem_re);
   assert_be_within_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |-> ((mem_be & ~cfg_plane_en) == '0));
   assert_chain_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && cfg_chain4) |-> $onehot0(mem_be));
   assert_chain_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr || host_rd) && cfg_chain4) |-> (mem_addr == (host_addr >> LIW)));
   assert_pair_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_wr || host_rd) && !cfg_chain4 && cfg_oddeven) |-> (mem_addr == (host_addr >> 1)));
   assert_pair_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !cfg_chain4 && cfg_oddeven) |-> $onehot0(mem_be));
endmodule

bind vgapl_plane_access vgapl_checker #(.HOST_AW(HOST_AW), .PLANES(PLANES)) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_addr    (host_addr),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .host_rvalid  (host_rvalid),
   .cfg_chain4   (cfg_chain4),
   .cfg_oddeven  (cfg_oddeven),
   .cfg_plane_en (cfg_plane_en),
   .mem_addr     (mem_addr),
   .mem_re       (mem_re),
   .mem_be       (mem_be)
);

// File: tb/vgapl_plane_access_bench.sv
`timescale 1ns/1ps
module vgapl_plane_access_bench;
   localparam int AW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_rdata;
   logic        host_rvalid;
   logic        cfg_chain4 = 0, cfg_oddeven = 0, cfg_read_mode = 0;
   logic [1:0]  cfg_read_plane = 0, cfg_write_mode = 0, cfg_alu_op = 0;
   logic [2:0]  cfg_rotate = 0;
   logic [3:0]  cfg_sr_value = 0, cfg_sr_enable = 0, cfg_plane_en = 4'hF;
   logic [3:0]  cfg_cmp_color = 0, cfg_cmp_care = 0;
   logic [7:0]  cfg_bit_mask = 8'hFF;
   logic [AW-1:0] mem_addr;
   logic        mem_we, mem_re;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic [31:0] mem [256];

   int checks = 0, fails = 0;
   logic [AW-1:0] got_addr;
   logic [3:0]  got_be;
   logic [31:0] got_wd;
   logic        got_re, got_rv;
   logic [7:0]  got_rd;
   logic [31:0] mlatch;

   always #5 clk = ~clk;

   vgapl_plane_access #(.HOST_AW(AW)) u_vgapl_plane_access (.*);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= (i * 32'h9E3779B1) ^ 32'h5A0F_C3A5;
         mem_rdata <= '0;
      end else begin
         if (mem_we)
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
         if (mem_re) mem_rdata <= mem[mem_addr];
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      #1;
      got_addr = mem_addr; got_be = mem_be; got_wd = mem_wdata; got_re = mem_re;
      @(posedge clk); @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [AW-1:0] a);
      host_addr = a; host_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      host_rd = 1'b0;
      got_rv = host_rvalid; got_rd = host_rdata;
   endtask

   function automatic logic [31:0] ref_write(input int wm, input int alu, input int d,
      input int r, input int srv, input int sre, input int bm, input logic [31:0] lat);
      logic [31:0] res;
      int rot, msk;
      rot = ((d >> r) | (d << (8 - r))) & 255;
      msk = (wm == 3) ? (bm & rot) : bm;
      for (int p = 0; p < 4; p++) begin
         int lp, s, a, o;
         lp = int'((lat >> (8 * p)) & 32'hFF);
         case (wm)
            0: s = ((sre >> p) & 1) ? (((srv >> p) & 1) ? 255 : 0) : rot;
            2: s = ((d >> p) & 1) ? 255 : 0;
            3: s = ((srv >> p) & 1) ? 255 : 0;
            default: s = lp;
         endcase
         case (alu)
            0: a = s;
            1: a = s & lp;
            2: a = s | lp;
            default: a = s ^ lp;
         endcase
         o = (wm == 1) ? lp : (((a & msk) | (lp & ~msk)) & 255);
         res[8*p +: 8] = o[7:0];
      end
      return res;
   endfunction

   function automatic logic [7:0] ref_cmp(input logic [31:0] w, input int col, input int care);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i] = 1'b1;
         for (int p = 0; p < 4; p++)
            if (((care >> p) & 1) && (w[8*p + i] != ((col >> p) & 1))) r[i] = 1'b0;
      end
      return r;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 rvalid after reset", {31'b0, host_rvalid}, 32'h0);
      cfg_write_mode = 2'd1; cfg_plane_en = 4'hF;
      do_wr(8'd250, 8'hAB);
      chk("R1 latch zero via copy write", got_wd, 32'h0);
      chk("R13 no rvalid after write", {31'b0, host_rvalid}, 32'h0);

      // R4 R6..R12: latched sweep over write modes and logic functions
      for (int wm = 0; wm < 4; wm++)
         for (int alu = 0; alu < 4; alu++)
            for (int k = 0; k < 6; k++) begin
               int a, d, r, srv, sre, bm, pe, rp;
               string tg;
               a   = (k * 37 + wm * 5 + alu * 11 + 40) & 255;
               d   = (k * 53 + wm * 17 + alu * 7 + 1) & 255;
               r   = (k + wm + alu) & 7;
               srv = (k * 3 + alu) & 15;
               sre = (k * 5 + wm) & 15;
               bm  = (k * 29 + alu * 11 + 3) & 255;
               pe  = (k == 5) ? ((wm * 4 + alu) & 15) : 15;
               rp  = (k + alu) & 3;
               cfg_chain4 = 0; cfg_oddeven = 0; cfg_read_mode = 0;
               cfg_read_plane = rp[1:0];
               mlatch = mem[a];
               do_rd(a[AW-1:0]);
               chk("R4 read mode 0 plane byte", {24'b0, got_rd}, {24'b0, mlatch[8*rp +: 8]});
               chk("R13 rvalid one cycle after read", {31'b0, got_rv}, 32'h1);
               cfg_write_mode = wm[1:0]; cfg_alu_op = alu[1:0]; cfg_rotate = r[2:0];
               cfg_sr_value = srv[3:0]; cfg_sr_enable = sre[3:0];
               cfg_bit_mask = bm[7:0]; cfg_plane_en = pe[3:0];
               do_wr(a[AW-1:0], d[7:0]);
               case (wm)
                  0: tg = "R6 R10 R11 write mode 0 data";
                  1: tg = "R7 write mode 1 data";
                  2: tg = "R8 R10 R11 write mode 2 data";
                  default: tg = "R9 R10 R11 write mode 3 data";
               endcase
               chk(tg, got_wd, ref_write(wm, alu, d, r, srv, sre, bm, mlatch));
               chk("R12 latched byte enables", {28'b0, got_be}, {28'b0, pe[3:0]});
               chk("R12 latched word address", {24'b0, got_addr}, a);
            end

      // R5: colour compare over all colour/care pairs
      cfg_plane_en = 4'hF; cfg_read_mode = 1'b1;
      for (int col = 0; col < 16; col++)
         for (int care = 0; care < 16; care++) begin
            int a;
            a = (col * 16 + care) & 255;
            cfg_cmp_color = col[3:0]; cfg_cmp_care = care[3:0];
            do_rd(a[AW-1:0]);
            chk("R5 colour compare", {24'b0, got_rd}, {24'b0, ref_cmp(mem[a], col, care)});
         end
      cfg_read_mode = 1'b0;

      // R2: chained mode; load the latch first to show reads leave it alone
      mlatch = mem[200];
      do_rd(8'd200);
      cfg_chain4 = 1'b1; cfg_oddeven = 1'b1;
      for (int a = 0; a < 32; a++) begin
         int pe, d, ln;
         pe = (a * 7 + 5) & 15; d = (a * 91 + 13) & 255; ln = a & 3;
         cfg_plane_en = pe[3:0];
         do_wr(a[AW-1:0], d[7:0]);
         chk("R2 chained word address", {24'b0, got_addr}, a >> 2);
         chk("R2 chained lane enable", {28'b0, got_be}, ((pe >> ln) & 1) ? (1 << ln) : 0);
         chk("R2 chained write data", got_wd, {4{d[7:0]}});
         do_rd(a[AW-1:0]);
         chk("R2 chained read byte", {24'b0, got_rd}, {24'b0, mem[a >> 2][8*ln +: 8]});
      end
      cfg_chain4 = 1'b0; cfg_oddeven = 1'b0;
      cfg_write_mode = 2'd1; cfg_plane_en = 4'hF;
      do_wr(8'd201, 8'h00);
      chk("R2 latch untouched by chained reads", got_wd, mlatch);

      // R3: paired odd/even mode with both pair selections
      cfg_oddeven = 1'b1;
      for (int sel = 0; sel < 2; sel++)
         for (int a = 0; a < 24; a++) begin
            int pe, d, pl;
            pe = (a * 5 + sel * 3 + 6) & 15; d = (a * 45 + sel * 99 + 7) & 255;
            pl = sel * 2 + (a & 1);
            cfg_read_plane = (sel == 1) ? 2'd2 : 2'd1;
            cfg_plane_en = pe[3:0];
            do_wr(a[AW-1:0], d[7:0]);
            chk("R3 paired word address", {24'b0, got_addr}, a >> 1);
            chk("R3 paired lane enable", {28'b0, got_be}, ((pe >> pl) & 1) ? (1 << pl) : 0);
            do_rd(a[AW-1:0]);
            chk("R3 paired read byte", {24'b0, got_rd}, {24'b0, mem[a >> 1][8*pl +: 8]});
         end
      cfg_oddeven = 1'b0;

      // R13: simultaneous read and write drops the read
      cfg_plane_en = 4'hF; cfg_write_mode = 2'd2; cfg_alu_op = 2'd0; cfg_bit_mask = 8'hFF;
      host_rd = 1'b1;
      do_wr(8'd99, 8'h05);
      host_rd = 1'b0;
      chk("R13 no memory read under write", {31'b0, got_re}, 32'h0);
      chk("R13 no rvalid under write", {31'b0, host_rvalid}, 32'h0);
      chk("R8 expand write under conflict", got_wd, 32'h00FF_00FF);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule